// File: doc/BRIEF.md
# Transmit/Receive FIFO Pair with Threshold Interrupts

This block is the byte buffering stage between a serial shift engine and the rest of a controller. It holds two byte FIFOs of a parameterised depth (64 or 128 entries). One carries outgoing bytes: software writes them in, and the shift engine takes them out. The other carries incoming bytes: the shift engine pushes them in, and software reads them out. Each FIFO has an occupancy count and its own programmable trigger level. Comparing the count against that level drives a sticky interrupt status bit and, when enabled, a level-sensitive DMA request.

Software reaches the block through a small word-wide register port. There are six registers: control, interrupt enable, interrupt status, fill levels, transmit data and receive data. Status bits are cleared by writing one to them. A status condition that is still true in the same cycle as the clear keeps its bit set. Software can therefore drain or refill a FIFO first and clear the bit afterwards without losing an event. Each FIFO can be emptied on its own through a self-clearing bit in the control register.

Top module: `xfer_fifo_pair`

## Requirements
- R1: During and after reset, both FIFOs are empty. The control, enable and status registers read zero until the first clock after reset. `irq`, `tx_dma_req` and `rx_dma_req` are low.
- R2: Bytes written to the transmit data address (4, byte in bits 7:0) leave on `tx_pop_data` in write order, one per `tx_pop` cycle. A write to the transmit data address while the transmit FIFO is full is dropped. A pop while it is empty has no effect.
- R3: Bytes pushed with `rx_push` are returned in push order from the receive data address (5, bits 7:0). A read with `reg_re` at that address removes the head byte.
- R4: The fill-level register (address 3) reports the receive count in bits 7:0 and the transmit count in bits 23:16. All other bits read zero.
- R5: The receive-ready status bit (status bit 0) is set one clock after the receive count is greater than or equal to the receive threshold. The receive threshold is control bits 7:0 at address 0.
- R6: The transmit-request status bit (status bit 4) is set one clock after the transmit count is less than or equal to the transmit threshold. The transmit threshold is control bits 23:16.
- R7: A push while the receive FIFO holds its full depth sets the overflow status bit (bit 8). The pushed byte is dropped and the count stays at the depth.
- R8: A one-cycle pulse on `xfer_done` sets the transfer-complete status bit (bit 12).
- R9: Writing one to a status bit at address 2 clears it. Writing all ones clears every bit. A set condition present in the same cycle as the clear wins, so the bit stays set.
- R10: `irq` is high exactly when some status bit is set and its enable bit is set. The enable register is at address 1 and uses the same bit positions as the status register.
- R11: `rx_dma_req` is high while control bit 8 is set and the receive count is at or above the receive threshold. `tx_dma_req` is high while control bit 24 is set and the transmit count is at or below the transmit threshold.
- R12: Writing control bit 15 (receive) or bit 31 (transmit) empties only that FIFO on the following clock. The written bit reads back as one for that single cycle and as zero afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (pops the receive FIFO at address 5) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| tx_pop | input | 1 | Shift engine takes the head transmit byte |
| tx_pop_data | output | 8 | Head byte of the transmit FIFO |
| tx_empty | output | 1 | Transmit FIFO holds no byte |
| rx_push | input | 1 | Shift engine delivers a received byte |
| rx_push_data | input | 8 | Received byte |
| xfer_done | input | 1 | One-cycle pulse at the end of a transfer |
| tx_dma_req | output | 1 | Transmit DMA request level |
| rx_dma_req | output | 1 | Receive DMA request level |
| irq | output | 1 | Combined masked interrupt |

## Verification
The assertions assume that the shift engine respects the FIFO state. It raises `tx_pop` only when `tx_empty` is low, and it pushes into a full receive FIFO only when an overflow is meant. The assertions also assume that software never reads the receive data address in the same cycle as a push into a full FIFO. Under these conditions, every count change is a single push or a single pop. The stimulus drives one source at a time: register accesses, pushes and pops are never issued together. Overflow is provoked deliberately, by one extra push after the receive FIFO has been filled to its depth.

// File: rtl/xfp_pkg.sv
package xfp_pkg;

  // Register addresses
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_IEN    = 3'd1,
    A_ISTS   = 3'd2,
    A_LEVEL  = 3'd3,
    A_TXDATA = 3'd4,
    A_RXDATA = 3'd5
  } xfp_addr_e;

  // Internal vector order of the four interrupt sources
  localparam int unsigned IRQ_N     = 4;
  localparam int unsigned IDX_RXRDY = 0;
  localparam int unsigned IDX_TXREQ = 1;
  localparam int unsigned IDX_RXOVF = 2;
  localparam int unsigned IDX_DONE  = 3;

  // Word positions of the sources in the enable and status registers
  localparam int unsigned POS_RXRDY = 0;
  localparam int unsigned POS_TXREQ = 4;
  localparam int unsigned POS_RXOVF = 8;
  localparam int unsigned POS_DONE  = 12;

  function automatic logic [IRQ_N-1:0] irq_unpack(input logic [31:0] w);
    return {w[POS_DONE], w[POS_RXOVF], w[POS_TXREQ], w[POS_RXRDY]};
  endfunction

  function automatic logic [31:0] irq_pack(input logic [IRQ_N-1:0] v);
    logic [31:0] w;
    w = '0;
    w[POS_RXRDY] = v[IDX_RXRDY];
    w[POS_TXREQ] = v[IDX_TXREQ];
    w[POS_RXOVF] = v[IDX_RXOVF];
    w[POS_DONE]  = v[IDX_DONE];
    return w;
  endfunction

  // Receive side: enough bytes waiting
  function automatic logic level_at_or_above(input logic [8:0] cnt, input logic [7:0] thr);
    return cnt >= {1'b0, thr};
  endfunction

  // Transmit side: room for a refill
  function automatic logic level_at_or_below(input logic [8:0] cnt, input logic [7:0] thr);
    return cnt <= {1'b0, thr};
  endfunction

  // Sticky bit with write-one-to-clear; a set in the same cycle wins
  function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/xfp_fifo.sv
module xfp_fifo #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned WIDTH = 8,
  localparam int unsigned AW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic [CW-1:0]    count,
  output logic             full,
  output logic             empty
);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem[rd_ptr];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/xfp_irq.sv
module xfp_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] sts,
  output logic         irq
);
  import xfp_pkg::*;

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bit_q <= 1'b0;
      else        bit_q <= sticky_next(bit_q, set[g], clr[g]);
    end
    assign sts[g] = bit_q;
  end

  assign irq = |(sts & en);

endmodule

// File: rtl/xfer_fifo_pair.sv
module xfer_fifo_pair #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_re,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        tx_pop,
  output logic [7:0]  tx_pop_data,
  output logic        tx_empty,
  input  logic        rx_push,
  input  logic [7:0]  rx_push_data,
  input  logic        xfer_done,
  output logic        tx_dma_req,
  output logic        rx_dma_req,
  output logic        irq
);
  import xfp_pkg::*;

  // Control fields
  logic [7:0] rx_thr, tx_thr;
  logic       rx_dma_en, tx_dma_en;
  logic       rx_rst_q, tx_rst_q;
  logic [IRQ_N-1:0] ien;

  // Decoded accesses
  logic wr_ctrl, wr_ien, wr_sts, wr_txd, rd_rxd;
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);
  assign wr_ien  = reg_we && (reg_addr == A_IEN);
  assign wr_sts  = reg_we && (reg_addr == A_ISTS);
  assign wr_txd  = reg_we && (reg_addr == A_TXDATA);
  assign rd_rxd  = reg_re && (reg_addr == A_RXDATA);

  // FIFO state brought out as named wires
  logic [CW-1:0] rx_cnt, tx_cnt;
  logic          rx_full, rx_empty, tx_full;
  logic [7:0]    rx_head;
  logic [8:0]    rx_cnt9, tx_cnt9;

  xfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(tx_rst_q),
    .push(wr_txd), .push_data(reg_wdata[7:0]),
    .pop(tx_pop), .head(tx_pop_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  xfp_fifo #(.DEPTH(DEPTH), .WIDTH(8)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(rx_rst_q),
    .push(rx_push), .push_data(rx_push_data),
    .pop(rd_rxd), .head(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign rx_cnt9 = 9'(rx_cnt);
  assign tx_cnt9 = 9'(tx_cnt);

  // Interrupt source events
  logic rx_rdy_cond, tx_req_cond, ovf_evt;
  assign rx_rdy_cond = level_at_or_above(rx_cnt9, rx_thr);
  assign tx_req_cond = level_at_or_below(tx_cnt9, tx_thr);
  assign ovf_evt     = rx_push & rx_full;

  logic [IRQ_N-1:0] sts_set, sts_clr, sts;
  always_comb begin
    sts_set            = '0;
    sts_set[IDX_RXRDY] = rx_rdy_cond;
    sts_set[IDX_TXREQ] = tx_req_cond;
    sts_set[IDX_RXOVF] = ovf_evt;
    sts_set[IDX_DONE]  = xfer_done;
  end
  assign sts_clr = wr_sts ? irq_unpack(reg_wdata) : '0;

  xfp_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .set(sts_set), .clr(sts_clr),
    .en(ien), .sts(sts), .irq(irq)
  );

  // Control and enable registers; FIFO reset bits live for one cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_thr    <= '0;
      tx_thr    <= '0;
      rx_dma_en <= 1'b0;
      tx_dma_en <= 1'b0;
      rx_rst_q  <= 1'b0;
      tx_rst_q  <= 1'b0;
      ien       <= '0;
    end else begin
      if (wr_ctrl) begin
        rx_thr    <= reg_wdata[7:0];
        rx_dma_en <= reg_wdata[8];
        rx_rst_q  <= reg_wdata[15];
        tx_thr    <= reg_wdata[23:16];
        tx_dma_en <= reg_wdata[24];
        tx_rst_q  <= reg_wdata[31];
      end else begin
        rx_rst_q  <= 1'b0;
        tx_rst_q  <= 1'b0;
      end
      if (wr_ien) ien <= irq_unpack(reg_wdata);
    end
  end

  assign rx_dma_req = rx_dma_en & rx_rdy_cond;
  assign tx_dma_req = tx_dma_en & tx_req_cond;

  // Read mux
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata = {tx_rst_q, 6'd0, tx_dma_en, tx_thr,
                             rx_rst_q, 6'd0, rx_dma_en, rx_thr};
      A_IEN:    reg_rdata = irq_pack(ien);
      A_ISTS:   reg_rdata = irq_pack(sts);
      A_LEVEL:  reg_rdata = {8'd0, 8'(tx_cnt), 8'd0, 8'(rx_cnt)};
      A_RXDATA: reg_rdata = {24'd0, rx_head};
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_sig;
  assign unused_sig = ^{reg_wdata[30:25], reg_wdata[14:9], tx_full, rx_empty};

endmodule

// File: rtl/xfp_chk.sv
module xfp_chk #(
  parameter int unsigned DEPTH = 128,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_push,
  input logic          rx_full,
  input logic          xfer_done,
  input logic          wr_sts,
  input logic          wr_ctrl,
  input logic          clr_done_bit,
  input logic [CW-1:0] rx_cnt,
  input logic [CW-1:0] tx_cnt,
  input logic [7:0]    rx_thr,
  input logic          rx_rdy_cond,
  input logic          tx_req_cond,
  input logic          rx_rst_q,
  input logic [3:0]    sts,
  input logic [3:0]    ien,
  input logic          irq,
  input logic          rx_dma_req
);

  a_r5_rxrdy_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rdy_cond |=> sts[0]);

  a_r6_txreq_sets: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_cond |=> sts[1]);

  a_r7_ovf_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> sts[2]);

  a_r7_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= CW'(DEPTH)) && (tx_cnt <= CW'(DEPTH)));

  a_r8_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> sts[3]);

  a_r9_clear_done: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && clr_done_bit && !xfer_done) |=> !sts[3]);

  a_r10_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == 4'd0) |-> !irq);

  a_r11_rxdma_level: assert property (@(posedge clk) disable iff (!rst_n)
    rx_dma_req |-> (9'(rx_cnt) >= 9'(rx_thr)));

  a_r12_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst_q |=> (rx_cnt == '0));

  a_r12_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rst_q && !wr_ctrl) |=> !rx_rst_q);

endmodule

bind xfer_fifo_pair xfp_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_full(rx_full),
  .xfer_done(xfer_done), .wr_sts(wr_sts), .wr_ctrl(wr_ctrl),
  .clr_done_bit(reg_wdata[12]), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .rx_thr(rx_thr), .rx_rdy_cond(rx_rdy_cond), .tx_req_cond(tx_req_cond),
  .rx_rst_q(rx_rst_q), .sts(sts), .ien(ien), .irq(irq),
  .rx_dma_req(rx_dma_req)
);

// File: tb/xfer_fifo_pair_tb.sv
module xfer_fifo_pair_tb;

  localparam int unsigned DEPTH = 128;
  localparam logic [2:0] AD_CTRL = 3'd0, AD_IEN = 3'd1, AD_STS = 3'd2,
                         AD_LVL = 3'd3, AD_TXD = 3'd4, AD_RXD = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        tx_pop = 1'b0;
  logic [7:0]  tx_pop_data;
  logic        tx_empty;
  logic        rx_push = 1'b0;
  logic [7:0]  rx_push_data = '0;
  logic        xfer_done = 1'b0;
  logic        tx_dma_req, rx_dma_req, irq;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  xfer_fifo_pair #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_pop(tx_pop), .tx_pop_data(tx_pop_data), .tx_empty(tx_empty),
    .rx_push(rx_push), .rx_push_data(rx_push_data), .xfer_done(xfer_done),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // All helpers start and end just after a falling edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push = 1'b1; rx_push_data = d;
    @(negedge clk);
    rx_push = 1'b0;
  endtask

  task automatic pop_rx(output logic [7:0] d);
    reg_addr = AD_RXD; reg_re = 1'b1;
    #1 d = reg_rdata[7:0];
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic pop_tx(output logic [7:0] d);
    #1 d = tx_pop_data;
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    repeat (2) @(negedge clk);
    rd(AD_CTRL, v); chk("R1", "ctrl in reset", v, 32'h0);
    rd(AD_IEN, v);  chk("R1", "enable in reset", v, 32'h0);
    rd(AD_STS, v);  chk("R1", "status in reset", v, 32'h0);
    rd(AD_LVL, v);  chk("R1", "levels in reset", v, 32'h0);
    chk("R1", "irq/dma in reset", {29'd0, irq, tx_dma_req, rx_dma_req}, 32'h0);
    chk("R1", "tx_empty in reset", {31'd0, tx_empty}, 32'h1);
    rst_n = 1'b1;
    idle();
  endtask

  task automatic t_tx_order();
    logic [31:0] v;
    logic [7:0] b;
    wr(AD_TXD, 32'hA1); wr(AD_TXD, 32'hB2); wr(AD_TXD, 32'hC3);
    rd(AD_LVL, v);
    chk("R4", "tx level field", v, 32'h0003_0000);
    pop_tx(b); chk("R2", "tx byte 0", {24'd0, b}, 32'hA1);
    pop_tx(b); chk("R2", "tx byte 1", {24'd0, b}, 32'hB2);
    pop_tx(b); chk("R2", "tx byte 2", {24'd0, b}, 32'hC3);
    pop_tx(b);
    rd(AD_LVL, v); chk("R2", "pop on empty keeps level", v, 32'h0);
    for (int i = 0; i <= DEPTH; i++) wr(AD_TXD, 32'(i) ^ 32'h5A);
    rd(AD_LVL, v); chk("R2", "tx full drops write", v[23:16], 32'(DEPTH));
    for (int i = 0; i < DEPTH; i++) begin
      pop_tx(b);
      chk("R2", "tx drain order", {24'd0, b}, 32'(8'(i) ^ 8'h5A));
    end
    chk("R2", "tx empty after drain", {31'd0, tx_empty}, 32'h1);
  endtask

  task automatic t_rx_order();
    logic [31:0] v;
    logic [7:0] b;
    push_rx(8'h5A); push_rx(8'h6B); push_rx(8'h7C);
    rd(AD_LVL, v); chk("R4", "rx level field", v, 32'h0000_0003);
    pop_rx(b); chk("R3", "rx byte 0", {24'd0, b}, 32'h5A);
    pop_rx(b); chk("R3", "rx byte 1", {24'd0, b}, 32'h6B);
    pop_rx(b); chk("R3", "rx byte 2", {24'd0, b}, 32'h7C);
    rd(AD_LVL, v); chk("R3", "rx empty after reads", v, 32'h0);
  endtask

  task automatic t_rx_thresh();
    logic [31:0] v;
    logic [7:0] b;
    wr(AD_CTRL, 32'h0000_0104);        // rx threshold 4, rx DMA on
    wr(AD_STS, 32'hFFFF_FFFF);
    rd(AD_STS, v); chk("R9", "all-ones clear of rx-ready", {31'd0, v[0]}, 32'h0);
    chk("R11", "rx dma low below threshold", {31'd0, rx_dma_req}, 32'h0);
    push_rx(8'h01); push_rx(8'h02); push_rx(8'h03);
    idle();
    rd(AD_STS, v); chk("R5", "rx-ready clear at 3 of 4", {31'd0, v[0]}, 32'h0);
    push_rx(8'h04);
    chk("R11", "rx dma high at threshold", {31'd0, rx_dma_req}, 32'h1);
    idle();
    rd(AD_STS, v); chk("R5", "rx-ready set at 4 of 4", {31'd0, v[0]}, 32'h1);
    wr(AD_STS, 32'h1);
    rd(AD_STS, v); chk("R9", "set wins over clear", {31'd0, v[0]}, 32'h1);
    for (int i = 0; i < 4; i++) pop_rx(b);
    chk("R11", "rx dma low after drain", {31'd0, rx_dma_req}, 32'h0);
    wr(AD_STS, 32'h1);
    rd(AD_STS, v); chk("R9", "clear after drain", {31'd0, v[0]}, 32'h0);
  endtask

  task automatic t_tx_thresh();
    logic [31:0] v;
    logic [7:0] b;
    wr(AD_CTRL, 32'h0102_0000);        // tx threshold 2, tx DMA on
    wr(AD_TXD, 32'h10); wr(AD_TXD, 32'h20); wr(AD_TXD, 32'h30);
    chk("R11", "tx dma low above threshold", {31'd0, tx_dma_req}, 32'h0);
    wr(AD_STS, 32'h10);
    rd(AD_STS, v); chk("R6", "tx-request clear at 3 > 2", {31'd0, v[4]}, 32'h0);
    pop_tx(b);
    chk("R11", "tx dma high at threshold", {31'd0, tx_dma_req}, 32'h1);
    idle();
    rd(AD_STS, v); chk("R6", "tx-request set at 2", {31'd0, v[4]}, 32'h1);
    pop_tx(b); pop_tx(b);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    logic [7:0] b;
    wr(AD_CTRL, 32'h0);
    wr(AD_STS, 32'hFFFF_FFFF);
    for (int i = 0; i < DEPTH; i++) push_rx(8'(i));
    rd(AD_LVL, v); chk("R7", "rx level at depth", v[7:0], 32'(DEPTH));
    rd(AD_STS, v); chk("R7", "no overflow when just full", {31'd0, v[8]}, 32'h0);
    push_rx(8'hEE);
    rd(AD_LVL, v); chk("R7", "rx level after overflow", v[7:0], 32'(DEPTH));
    rd(AD_STS, v); chk("R7", "overflow bit", {31'd0, v[8]}, 32'h1);
    for (int i = 0; i < DEPTH; i++) begin
      pop_rx(b);
      chk("R7", "rx content kept, extra dropped", {24'd0, b}, 32'(8'(i)));
    end
    wr(AD_STS, 32'h100);
    rd(AD_STS, v); chk("R9", "overflow cleared", {31'd0, v[8]}, 32'h0);
  endtask

  task automatic t_done_irq();
    logic [31:0] v;
    wr(AD_IEN, 32'h0);
    wr(AD_STS, 32'hFFFF_FFFF);
    rd(AD_STS, v); chk("R8", "done clear before pulse", {31'd0, v[12]}, 32'h0);
    xfer_done = 1'b1; @(negedge clk); xfer_done = 1'b0;
    rd(AD_STS, v); chk("R8", "done set after pulse", {31'd0, v[12]}, 32'h1);
    chk("R10", "irq masked", {31'd0, irq}, 32'h0);
    wr(AD_IEN, 32'h1000);
    rd(AD_IEN, v); chk("R10", "enable readback", v, 32'h1000);
    chk("R10", "irq on done enabled", {31'd0, irq}, 32'h1);
    wr(AD_IEN, 32'h100);
    chk("R10", "irq off with only overflow enabled", {31'd0, irq}, 32'h0);
    wr(AD_IEN, 32'h1);                 // rx threshold 0: rx-ready held set
    chk("R10", "irq on rx-ready enabled", {31'd0, irq}, 32'h1);
    wr(AD_IEN, 32'h1000);
    wr(AD_STS, 32'h1000);
    rd(AD_STS, v); chk("R9", "done cleared by one", {31'd0, v[12]}, 32'h0);
    chk("R10", "irq off after clear", {31'd0, irq}, 32'h0);
    wr(AD_IEN, 32'h0);
  endtask

  task automatic t_fifo_reset();
    logic [31:0] v;
    wr(AD_TXD, 32'h11);
    push_rx(8'h21); push_rx(8'h22);
    wr(AD_CTRL, 32'h0000_8000);
    rd(AD_CTRL, v); chk("R12", "rx reset bit reads one", {31'd0, v[15]}, 32'h1);
    rd(AD_LVL, v);  chk("R12", "levels before flush edge", v, 32'h0001_0002);
    idle();
    rd(AD_CTRL, v); chk("R12", "rx reset bit self-clears", {31'd0, v[15]}, 32'h0);
    rd(AD_LVL, v);  chk("R12", "only rx flushed", v, 32'h0001_0000);
    wr(AD_CTRL, 32'h8000_0000);
    idle();
    rd(AD_CTRL, v); chk("R12", "tx reset bit self-clears", {31'd0, v[31]}, 32'h0);
    rd(AD_LVL, v);  chk("R12", "tx flushed", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_tx_order();
    t_rx_order();
    t_rx_thresh();
    t_tx_thresh();
    t_overflow();
    t_done_irq();
    t_fifo_reset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual run still going, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule